// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the source and destination word addresses for a memory-to-memory DMA stream that moves a rectangle of words. Software sets up a start address and a signed byte stride for each side. It also sets a row length in beats and a row count, which both sides share. A start pulse launches the run. The block then offers one address pair per beat on a valid/ready handshake. The bus master takes a pair when it can issue the read and the write.

Inside a row, each beat moves both addresses up by one word. When a row ends, each side adds its own stride to the address that would follow the row's last word. A positive stride leaves a gap between rows, a negative one walks back, and all sums wrap modulo 2^32.

A legality check runs at the start pulse. Any transfer setting that the 2D mode forbids causes the start to be refused and flagged. A start with a zero row length or a zero row count finishes at once without issuing any beats.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, and whenever reset is asserted, `beat_valid`, `busy`, `done` and `cfg_err` are low.
- R2: A start pulse that is accepted, with a legal setup and nonzero counts, raises `beat_valid` and `busy` in the next cycle. At that point `src_addr` and `dst_addr` equal the programmed start addresses.
- R3: Within a row, each accepted beat moves each address up by exactly 4 bytes, modulo 2^32.
- R4: After the last beat of a row, the next address on each side is the last address plus 4 plus that side's two's-complement stride, modulo 2^32.
- R5: A run issues exactly `row_beats * row_count` beats. Both sides use the shared counts, but each side has its own start address and stride.
- R6: The pair advances only on a cycle where `beat_valid` and `beat_ready` are both high. While `beat_ready` is low, both addresses and `beat_valid` hold.
- R7: `done` is high for exactly one cycle, in the cycle after the last beat is accepted. `beat_valid` and `busy` are low in that same cycle.
- R8: If `row_beats` or `row_count` is zero when a legal start is taken, `done` pulses in the next cycle and no beat is offered.
- R9: A setup is legal only if every one of these holds:
  - `xfer_dir` equals 2'b10 (memory to memory).
  - `src_size` and `dst_size` both equal 2'b10 (word).
  - `src_incr` and `dst_incr` are both 1.
  - `flow_by_periph`, `periph_ofs_incr`, `circular`, `double_buf` and `chained` are all 0.
  - Bits [1:0] of both strides are 0.
  A start with any other setup gives a one-cycle `cfg_err` pulse in the next cycle, with no beat and no `done`.
- R10: A start pulse while `busy` is high is ignored, and the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch pulse, taken only while idle |
| xfer_dir | input | 2 | Transfer direction code, 2'b10 = memory to memory |
| src_size | input | 2 | Source data size code, 2'b10 = word |
| dst_size | input | 2 | Destination data size code, 2'b10 = word |
| src_incr | input | 1 | Source address increment enable |
| dst_incr | input | 1 | Destination address increment enable |
| flow_by_periph | input | 1 | Peripheral-controlled flow, must be 0 |
| periph_ofs_incr | input | 1 | Fixed-offset peripheral increment, must be 0 |
| circular | input | 1 | Circular mode, must be 0 |
| double_buf | input | 1 | Double-buffer mode, must be 0 |
| chained | input | 1 | Linked-descriptor mode, must be 0 |
| src_start | input | 32 | Source start byte address |
| dst_start | input | 32 | Destination start byte address |
| src_stride | input | 32 | Source row stride in bytes, two's complement |
| dst_stride | input | 32 | Destination row stride in bytes, two's complement |
| row_beats | input | 16 | Beats per row |
| row_count | input | 16 | Number of rows |
| beat_ready | input | 1 | Consumer takes the current address pair |
| beat_valid | output | 1 | Address pair is on offer |
| src_addr | output | 32 | Source byte address of the current beat |
| dst_addr | output | 32 | Destination byte address of the current beat |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| cfg_err | output | 1 | One-cycle pulse for a refused start |

## Verification
The bound checker watches the handshake hold and the one-cycle shape of `done`. It also checks that `done` and `cfg_err` never coincide with an offered beat. For every accepted beat, it checks that each address moved either by one word or by one word plus its stride latched at start.

Only the bench scenarios can show that the step is chosen at the right beat and that the beat total matches the counts. The same holds for the address values after wrap-around and negative strides, each of the refused settings, the zero-count shortcut, and a start ignored in mid-run.

// File: rtl/dma2d_pkg.sv
// Shared codes and types for the 2D address generator.
// Assumes word beats of 4 bytes; codes below are the only legal 2D settings.
package dma2d_pkg;
    localparam logic [1:0] DIR_MEM2MEM = 2'b10;
    localparam logic [1:0] SIZE_WORD   = 2'b10;

    typedef struct packed {
        logic [1:0] dir;
        logic [1:0] src_size;
        logic [1:0] dst_size;
        logic       src_incr;
        logic       dst_incr;
        logic       flow_by_periph;
        logic       periph_ofs_incr;
        logic       circular;
        logic       double_buf;
        logic       chained;
    } xfer_mode_t;

    typedef enum logic {GEN_IDLE = 1'b0, GEN_RUN = 1'b1} gen_state_t;
endpackage

// File: rtl/dma2d_cfg_check.sv
// Combinational legality check of a 2D setup.
// Assumes strides are byte strides; word alignment means low log2(BEAT_BYTES) bits clear.
module dma2d_cfg_check
    import dma2d_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BEAT_BYTES = 4
) (
    input  xfer_mode_t        mode,
    input  logic [ADDR_W-1:0] src_stride,
    input  logic [ADDR_W-1:0] dst_stride,
    output logic              legal
);
    localparam int ALIGN_BITS = $clog2(BEAT_BYTES);

    logic mode_ok;
    logic align_ok;

    // Mode fields must match the single allowed 2D combination.
    always_comb begin
        mode_ok = (mode.dir == DIR_MEM2MEM) && (mode.src_size == SIZE_WORD)
               && (mode.dst_size == SIZE_WORD) && mode.src_incr && mode.dst_incr
               && !mode.flow_by_periph && !mode.periph_ofs_incr
               && !mode.circular && !mode.double_buf && !mode.chained;
    end

    // Both strides must be whole words.
    always_comb begin
        align_ok = (src_stride[ALIGN_BITS-1:0] == '0) && (dst_stride[ALIGN_BITS-1:0] == '0);
    end

    // Final verdict.
    always_comb legal = mode_ok && align_ok;
endmodule

// File: rtl/dma2d_beat_cnt.sv
// Column/row position tracker shared by both address sides.
// Assumes load only with nonzero limits; step only while a run is active.
module dma2d_beat_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [CNT_W-1:0] col_lim,
    input  logic [CNT_W-1:0] row_lim,
    output logic             row_end,
    output logic             last_beat
);
    logic [CNT_W-1:0] col_q, row_q, col_lim_q, row_lim_q;

    // Position and limits: cleared on load, advanced on each accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q     <= '0;
            row_q     <= '0;
            col_lim_q <= '0;
            row_lim_q <= '0;
        end else if (load) begin
            col_q     <= '0;
            row_q     <= '0;
            col_lim_q <= col_lim;
            row_lim_q <= row_lim;
        end else if (step) begin
            if (row_end) begin
                col_q <= '0;
                row_q <= row_q + 1'b1;
            end else begin
                col_q <= col_q + 1'b1;
            end
        end
    end

    // Row and run boundary flags for the current beat.
    always_comb begin
        row_end   = (col_q == col_lim_q - 1'b1);
        last_beat = row_end && (row_q == row_lim_q - 1'b1);
    end
endmodule

// File: rtl/dma2d_addr_side.sv
// One address walker (source or destination side).
// Assumes stride is a two's-complement byte value; sums wrap modulo 2^ADDR_W.
module dma2d_addr_side #(
    parameter int ADDR_W     = 32,
    parameter int BEAT_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              row_end,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] stride,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(BEAT_BYTES);

    logic [ADDR_W-1:0] addr_q, stride_q, next_addr;

    // Next address: one word on, plus the stride at a row boundary.
    always_comb next_addr = addr_q + WORD_STEP + (row_end ? stride_q : '0);

    // Address register with the stride captured at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            stride_q <= '0;
        end else if (load) begin
            addr_q   <= base;
            stride_q <= stride;
        end else if (step) begin
            addr_q   <= next_addr;
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/dma2d_addr_gen.sv
// Top of the 2D DMA address generator: start control, legality gate,
// shared beat counter and two address walkers. Assumes start is a pulse.
module dma2d_addr_gen
    import dma2d_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 16,
    parameter int BEAT_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        xfer_dir,
    input  logic [1:0]        src_size,
    input  logic [1:0]        dst_size,
    input  logic              src_incr,
    input  logic              dst_incr,
    input  logic              flow_by_periph,
    input  logic              periph_ofs_incr,
    input  logic              circular,
    input  logic              double_buf,
    input  logic              chained,
    input  logic [ADDR_W-1:0] src_start,
    input  logic [ADDR_W-1:0] dst_start,
    input  logic [ADDR_W-1:0] src_stride,
    input  logic [ADDR_W-1:0] dst_stride,
    input  logic [CNT_W-1:0]  row_beats,
    input  logic [CNT_W-1:0]  row_count,
    input  logic              beat_ready,
    output logic              beat_valid,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              busy,
    output logic              done,
    output logic              cfg_err
);
    localparam int SIDES = 2;

    gen_state_t        state_q;
    xfer_mode_t        mode;
    logic              legal, zero_len, take_start, load, fire, row_end, last_beat;
    logic              done_q, cfg_err_q;
    logic [ADDR_W-1:0] side_base   [SIDES];
    logic [ADDR_W-1:0] side_stride [SIDES];
    logic [ADDR_W-1:0] side_addr   [SIDES];

    // Gather the mode pins into one record for the checker.
    always_comb begin
        mode.dir             = xfer_dir;
        mode.src_size        = src_size;
        mode.dst_size        = dst_size;
        mode.src_incr        = src_incr;
        mode.dst_incr        = dst_incr;
        mode.flow_by_periph  = flow_by_periph;
        mode.periph_ofs_incr = periph_ofs_incr;
        mode.circular        = circular;
        mode.double_buf      = double_buf;
        mode.chained         = chained;
    end

    dma2d_cfg_check #(.ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES)) u_cfg (
        .mode       (mode),
        .src_stride (src_stride),
        .dst_stride (dst_stride),
        .legal      (legal)
    );

    // Launch decode and handshake.
    always_comb begin
        take_start = start && (state_q == GEN_IDLE);
        zero_len   = (row_beats == '0) || (row_count == '0);
        load       = take_start && legal && !zero_len;
        fire       = (state_q == GEN_RUN) && beat_ready;
    end

    // Run state with one-cycle done and error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= GEN_IDLE;
            done_q    <= 1'b0;
            cfg_err_q <= 1'b0;
        end else begin
            done_q    <= 1'b0;
            cfg_err_q <= 1'b0;
            case (state_q)
                GEN_IDLE: begin
                    if (take_start) begin
                        if (!legal)        cfg_err_q <= 1'b1;
                        else if (zero_len) done_q    <= 1'b1;
                        else               state_q   <= GEN_RUN;
                    end
                end
                GEN_RUN: begin
                    if (fire && last_beat) begin
                        state_q <= GEN_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= GEN_IDLE;
            endcase
        end
    end

    dma2d_beat_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (fire),
        .col_lim   (row_beats),
        .row_lim   (row_count),
        .row_end   (row_end),
        .last_beat (last_beat)
    );

    // Side inputs: index 0 is source, 1 is destination.
    always_comb begin
        side_base[0]   = src_start;
        side_base[1]   = dst_start;
        side_stride[0] = src_stride;
        side_stride[1] = dst_stride;
    end

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        dma2d_addr_side #(.ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES)) u_side (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load),
            .step    (fire),
            .row_end (row_end),
            .base    (side_base[s]),
            .stride  (side_stride[s]),
            .addr    (side_addr[s])
        );
    end

    assign src_addr   = side_addr[0];
    assign dst_addr   = side_addr[1];
    assign beat_valid = (state_q == GEN_RUN);
    assign busy       = (state_q == GEN_RUN);
    assign done       = done_q;
    assign cfg_err    = cfg_err_q;
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
// Property checker bound to dma2d_addr_gen. Captures the strides at launch
// on its own and checks handshake and address-step rules each cycle.
module dma2d_addr_gen_chk #(
    parameter int ADDR_W     = 32,
    parameter int BEAT_BYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              beat_ready,
    input logic              beat_valid,
    input logic [ADDR_W-1:0] src_addr,
    input logic [ADDR_W-1:0] dst_addr,
    input logic [ADDR_W-1:0] src_stride,
    input logic [ADDR_W-1:0] dst_stride,
    input logic              busy,
    input logic              done,
    input logic              cfg_err
);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(BEAT_BYTES);

    logic [ADDR_W-1:0] s_str_q, d_str_q;

    // Independent copy of the strides taken when an idle start arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_str_q <= '0;
            d_str_q <= '0;
        end else if (start && !busy) begin
            s_str_q <= src_stride;
            d_str_q <= dst_stride;
        end
    end

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !beat_ready |=> beat_valid && $stable(src_addr) && $stable(dst_addr));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !beat_valid && !busy);

    // R9
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !beat_valid && !done);

    // R3 / R4 source side
    src_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_ready |=> !beat_valid
            || src_addr == $past(src_addr) + WORD_STEP
            || src_addr == $past(src_addr) + WORD_STEP + s_str_q);

    // R3 / R4 destination side
    dst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_ready |=> !beat_valid
            || dst_addr == $past(dst_addr) + WORD_STEP
            || dst_addr == $past(dst_addr) + WORD_STEP + d_str_q);
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .beat_ready (beat_ready),
    .beat_valid (beat_valid),
    .src_addr   (src_addr),
    .dst_addr   (dst_addr),
    .src_stride (src_stride),
    .dst_stride (dst_stride),
    .busy       (busy),
    .done       (done),
    .cfg_err    (cfg_err)
);

// File: tb/dma2d_addr_gen_test.sv
`timescale 1ns/1ps
module dma2d_addr_gen_test;
    typedef struct packed {
        logic [15:0] xc;
        logic [15:0] yc;
        logic [31:0] ss;
        logic [31:0] ds;
        logic [31:0] sst;
        logic [31:0] dst;
        logic        stall;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{16'd4, 16'd8, 32'h0000_1000, 32'h0000_2000, 32'h0000_0000, 32'h0000_0010, 1'b0},
        '{16'd3, 16'd3, 32'h0000_0100, 32'h0000_8000, 32'hFFFF_FFF8, 32'h0000_000C, 1'b1},
        '{16'd1, 16'd5, 32'h0000_0040, 32'h0000_0000, 32'h0000_0004, 32'hFFFF_FFFC, 1'b0},
        '{16'd5, 16'd1, 32'h0000_0200, 32'h0000_0300, 32'h0000_0040, 32'h0000_0040, 1'b1},
        '{16'd2, 16'd2, 32'hFFFF_FFF8, 32'h0000_0010, 32'h0000_0000, 32'h0000_0000, 1'b0},
        '{16'd2, 16'd3, 32'h0000_1000, 32'h0000_4000, 32'hFFFF_FFE0, 32'h0000_0020, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  xfer_dir = 2'b10, src_size = 2'b10, dst_size = 2'b10;
    logic        src_incr = 1'b1, dst_incr = 1'b1;
    logic        flow_by_periph = 1'b0, periph_ofs_incr = 1'b0;
    logic        circular = 1'b0, double_buf = 1'b0, chained = 1'b0;
    logic [31:0] src_start = '0, dst_start = '0, src_stride = '0, dst_stride = '0;
    logic [15:0] row_beats = '0, row_count = '0;
    logic        beat_ready = 1'b0;
    logic        beat_valid, busy, done, cfg_err;
    logic [31:0] src_addr, dst_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dma2d_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .xfer_dir(xfer_dir), .src_size(src_size), .dst_size(dst_size),
        .src_incr(src_incr), .dst_incr(dst_incr),
        .flow_by_periph(flow_by_periph), .periph_ofs_incr(periph_ofs_incr),
        .circular(circular), .double_buf(double_buf), .chained(chained),
        .src_start(src_start), .dst_start(dst_start),
        .src_stride(src_stride), .dst_stride(dst_stride),
        .row_beats(row_beats), .row_count(row_count),
        .beat_ready(beat_ready), .beat_valid(beat_valid),
        .src_addr(src_addr), .dst_addr(dst_addr),
        .busy(busy), .done(done), .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic legal_mode();
        xfer_dir = 2'b10; src_size = 2'b10; dst_size = 2'b10;
        src_incr = 1'b1; dst_incr = 1'b1;
        flow_by_periph = 1'b0; periph_ofs_incr = 1'b0;
        circular = 1'b0; double_buf = 1'b0; chained = 1'b0;
    endtask

    // Launch one run and follow it beat by beat; poke re-issues start mid-run (R10).
    task automatic run_case(input vec_t v, input bit poke);
        int r = 0, c = 0, beats = 0, cyc = 0, last_acc = -10;
        bit done_seen = 1'b0, poked = 1'b0;
        logic [31:0] es, ed;
        int total = int'(v.xc) * int'(v.yc);
        row_beats = v.xc; row_count = v.yc;
        src_start = v.ss; dst_start = v.ds; src_stride = v.sst; dst_stride = v.dst;
        beat_ready = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(beat_valid && busy && src_addr == v.ss && dst_addr == v.ds, "R2",
              {src_addr, dst_addr}, {v.ss, v.ds});
        while (!done_seen && cyc < 4000) begin
            if (done) begin
                done_seen = 1'b1;
                check(beats == total, "R5", 64'(beats), 64'(total));
                check(last_acc == cyc - 1, "R7 done timing", 64'(cyc - last_acc), 64'd1);
                check(!beat_valid && !busy, "R7 idle with done", {beat_valid, busy}, 64'd0);
            end else begin
                beat_ready = v.stall ? cyc[0] : 1'b1;
                if (poke && beats == 1 && !poked) begin
                    poked = 1'b1;
                    start = 1'b1; src_start = 32'h9000_0000; row_beats = 16'd1;
                end
                if (beat_valid && beat_ready) begin
                    es = v.ss + 32'(r) * (32'(v.xc) * 32'd4 + v.sst) + 32'(c) * 32'd4;
                    ed = v.ds + 32'(r) * (32'(v.xc) * 32'd4 + v.dst) + 32'(c) * 32'd4;
                    check(src_addr == es, (c == 0 && r > 0) ? "R4 src" : "R3 src", src_addr, es);
                    check(dst_addr == ed, (c == 0 && r > 0) ? "R4 dst" : "R3 dst", dst_addr, ed);
                    beats++;
                    last_acc = cyc;
                    if (c == int'(v.xc) - 1) begin c = 0; r++; end else c++;
                end
                @(negedge clk);
                cyc++;
                start = 1'b0;
                if (poked) begin src_start = v.ss; row_beats = v.xc; end
            end
        end
        check(done_seen, "R7 done seen", 64'(done_seen), 64'd1);
        beat_ready = 1'b0;
        @(negedge clk);
        check(!done, "R7 single pulse", 64'(done), 64'd0);
    endtask

    // Refused start: apply one bad field, expect a lone cfg_err pulse (R9).
    task automatic bad_start(input int k);
        legal_mode();
        row_beats = 16'd2; row_count = 16'd2;
        src_stride = 32'h10; dst_stride = 32'h10;
        case (k)
            0: xfer_dir = 2'b01;
            1: src_size = 2'b01;
            2: dst_size = 2'b00;
            3: src_incr = 1'b0;
            4: dst_incr = 1'b0;
            5: flow_by_periph = 1'b1;
            6: periph_ofs_incr = 1'b1;
            7: circular = 1'b1;
            8: double_buf = 1'b1;
            9: chained = 1'b1;
            10: src_stride = 32'h6;
            default: dst_stride = 32'h2;
        endcase
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(cfg_err && !beat_valid && !done, $sformatf("R9 case %0d", k),
              {cfg_err, beat_valid, done}, 64'b100);
        @(negedge clk);
        check(!cfg_err && !beat_valid && !done && !busy, $sformatf("R9 quiet %0d", k),
              {cfg_err, beat_valid, done, busy}, 64'd0);
        legal_mode();
    endtask

    initial begin
        #(5ns * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!beat_valid && !busy && !done && !cfg_err, "R1 reset",
              {beat_valid, busy, done, cfg_err}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!beat_valid && !busy && !done && !cfg_err, "R1 after release",
              {beat_valid, busy, done, cfg_err}, 64'd0);

        for (int i = 0; i < NV; i++) run_case(VECS[i], 1'b0);

        // R10: start pulse while running is ignored
        run_case('{16'd3, 16'd2, 32'h0000_0500, 32'h0000_0600, 32'h0000_0008, 32'hFFFF_FFF4, 1'b0}, 1'b1);

        // R6: stalled beat holds its pair
        row_beats = 16'd2; row_count = 16'd2;
        src_start = 32'h7000; dst_start = 32'h7100; src_stride = '0; dst_stride = '0;
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        check(beat_valid && src_addr == 32'h7000 && dst_addr == 32'h7100, "R6 hold",
              {src_addr, dst_addr}, {32'h7000, 32'h7100});
        beat_ready = 1'b1; @(negedge clk); beat_ready = 1'b0;
        check(src_addr == 32'h7004 && dst_addr == 32'h7104, "R6 advance",
              {src_addr, dst_addr}, {32'h7004, 32'h7104});

        // R1: reset in mid-run clears everything
        rst_n = 1'b0; @(negedge clk);
        check(!beat_valid && !busy && !done, "R1 mid-run reset", {beat_valid, busy, done}, 64'd0);
        rst_n = 1'b1; @(negedge clk);

        // R8: zero counts finish at once
        for (int z = 0; z < 2; z++) begin
            row_beats = (z == 0) ? 16'd0 : 16'd4;
            row_count = (z == 0) ? 16'd3 : 16'd0;
            start = 1'b1; @(negedge clk); start = 1'b0;
            check(done && !beat_valid && !busy, "R8 immediate done", {done, beat_valid, busy}, 64'b100);
            @(negedge clk);
            check(!done && !beat_valid, "R8 no beats", {done, beat_valid}, 64'd0);
        end

        for (int k = 0; k < 12; k++) bad_start(k);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule